// File: doc/BRIEF.md
# Protected Register Write Guard

This block sits on a simple peripheral register bus and guards three special registers against stray writes. Software opens a single-write unlock window by writing a command register. The next bus write must target a special register. If it does, that register is updated. If it does not, or if a special register is written with no window open, a sticky protection-error flag is raised and any special-register write is dropped.

Software reads and clears the flag through an 8-bit status register. The flag sits in bit 0, and writing 0 there is the only way to clear it apart from reset. Plain reads inside the window leave it open, with one exception. The first special register (the watchdog-mode slot) tolerates no intervening access at all. The read half of a read-modify-write bit operation breaks the window in the same way a write would.

Registers accept either a full byte or a single bit. A single-bit write puts write-data bit 0 into the selected bit position.

Top module: `prot_wr_guard`

## Requirements
- R1: After reset, `prot_err` is 0, a status read returns 8'h00, every special register reads 8'h00, and no unlock window is open.
- R2: A status read returns the error flag in bit 0 and zero in bits 7 to 1.
- R3: A special-register write that directly follows a command write stores its data and leaves the flag unchanged. A byte write replaces all 8 bits. A bit write (`bus_bit`=1) replaces bit `bus_bitpos` with `bus_wdata[0]`.
- R4: A special-register write with no open window is discarded, and it sets the flag one cycle later.
- R5: After a command write, a next write to any address other than a special register sets the flag. This includes the status register with data bit 0 = 1, and other addresses, whether or not `bus_rmw` is set. That write closes the window.
- R6: A read with `bus_rmw`=0 inside an open window sets no flag and keeps the window open for special registers 1 and 2. The bus never raises `bus_wr` and `bus_rd` together.
- R7: Special register 0 (the watchdog-mode slot) is unlocked only when no access at all comes between the command write and its write. After an intervening read, its write is discarded and sets the flag.
- R8: A read with `bus_rmw`=1 while the window is open sets the flag and closes the window.
- R9: The flag clears only on a status write carrying 0 in bit 0, either as a byte write or as a bit write with `bus_bitpos`=0. Writing 1 when no window is open, or a bit write to status bits 1 to 7, leaves the flag unchanged.
- R10: A status write of 0 to bit 0 that directly follows a command write clears the flag. The clear wins over the error set.
- R11: Command-register reads return 0, and command writes store no data.
- R12: Two command writes in a row set the flag. The second write opens a fresh window, so a special write right after it succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| bus_bitpos | input | 3 | Bit index for single-bit access |
| bus_rmw | input | 1 | Marks the access as part of a read-modify-write bit operation |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
The assertions assume that each cycle carries at most one access, so `bus_wr` and `bus_rd` are never high together. Every bench access is a single-cycle strobe that raises exactly one of the two, and that assumption is itself checked. Random traffic is weighted toward command writes followed by special, status and foreign accesses. This places windows, intervening reads and bit-operation reads back to back. Directed sequences cover the precedence cases: clear against set, a repeated command write, and the watchdog slot after a read.

// File: rtl/prot_wr_guard.sv
module prot_wr_guard #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NSPEC     = 3,
  parameter int STRICT_IX = 0,
  parameter logic [ADDR_W-1:0] A_CMD   = 8'h00,
  parameter logic [ADDR_W-1:0] A_STAT  = 8'h04,
  parameter logic [ADDR_W-1:0] A_SPEC0 = 8'h10,
  parameter int SPEC_STRIDE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic                       bus_bit,
  input  logic [$clog2(DATA_W)-1:0]  bus_bitpos,
  input  logic                       bus_rmw,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       prot_err
);
  localparam int BP_W = $clog2(DATA_W);

  logic win_open, win_taint, err_q;
  logic [DATA_W-1:0] spec_q [NSPEC];
  logic [NSPEC-1:0]  spec_hit;

  genvar g;
  generate
    for (g = 0; g < NSPEC; g++) begin : g_hit
      assign spec_hit[g] = (bus_addr == A_SPEC0 + ADDR_W'(g * SPEC_STRIDE));
    end
  endgenerate

  wire is_cmd  = (bus_addr == A_CMD);
  wire is_stat = (bus_addr == A_STAT);
  wire is_spec = |spec_hit;
  wire rmw_rd  = bus_rd & bus_rmw & ~bus_wr;

  wire spec_ok = win_open & is_spec & ~(spec_hit[STRICT_IX] & win_taint);
  wire err_set = (bus_wr & (is_spec ? ~spec_ok : win_open)) | (rmw_rd & win_open);
  wire stat_b0 = bus_wr & is_stat & (~bus_bit | (bus_bitpos == '0));
  wire err_clr = stat_b0 & ~bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      win_open  <= 1'b0;
      win_taint <= 1'b0;
    end else begin
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      if (bus_wr) begin
        win_open  <= is_cmd;
        win_taint <= 1'b0;
      end else if (bus_rd && win_open) begin
        if (bus_rmw) win_open  <= 1'b0;
        else         win_taint <= 1'b1;
      end
    end
  end

  generate
    for (g = 0; g < NSPEC; g++) begin : g_spec
      always_ff @(posedge clk) begin
        if (!rst_n) spec_q[g] <= '0;
        else if (bus_wr && spec_ok && spec_hit[g]) begin
          if (bus_bit) spec_q[g][bus_bitpos] <= bus_wdata[0];
          else         spec_q[g] <= bus_wdata;
        end
      end

      // R3
      spec_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spec_q[g]) |-> $past(win_open && bus_wr));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (is_stat) bus_rdata[0] = err_q;
    for (int i = 0; i < NSPEC; i++)
      if (spec_hit[i]) bus_rdata = spec_q[i];
  end

  assign prot_err = err_q;

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R4
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_err) |-> $past(bus_wr || (bus_rd && bus_rmw)));

  // R9
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_err) |-> $past(bus_wr && is_stat && !bus_wdata[0]));

  // R5
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_cmd) |=> !win_open);

  // R8
  rmw_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_rd && win_open) |=> (!win_open && prot_err));
endmodule

// File: tb/prot_wr_guard_bench.sv
`timescale 1ns/1ps
module prot_wr_guard_bench;
  localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_SP0 = 8'h10, A_SP1 = 8'h14,
                         A_SP2 = 8'h18, A_OTH = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr = 0, rd = 0, bt = 0, rmw = 0;
  logic [2:0] pos = 0;
  logic [7:0] rdata;
  logic perr;

  int n_chk = 0, n_fail = 0;
  logic m_err = 0, m_win = 0, m_taint = 0;
  logic [7:0] m_spec [3];

  always #2.5 clk = ~clk;

  prot_wr_guard u_prot_wr_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
    .bus_rd(rd), .bus_bit(bt), .bus_bitpos(pos), .bus_rmw(rmw),
    .bus_rdata(rdata), .prot_err(perr));

  function automatic int sidx(input logic [7:0] a);
    if (a == A_SP0) return 0;
    if (a == A_SP1) return 1;
    if (a == A_SP2) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int i = sidx(a);
    if (i >= 0) return m_spec[i];
    if (a == A_STAT) return {7'b0, m_err};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic r, input logic mr,
                            input logic [7:0] a, input logic [7:0] d,
                            input logic b, input logic [2:0] p);
    int i = sidx(a);
    logic ok, set, clr;
    ok  = m_win && i >= 0 && !(i == 0 && m_taint);
    set = 0; clr = 0;
    if (w) begin
      if (i >= 0) set = !ok;
      else set = m_win;
      if (a == A_STAT && (!b || p == 0) && !d[0]) clr = 1;
      if (ok) begin
        if (b) m_spec[i][p] = d[0];
        else   m_spec[i] = d;
      end
      m_win = (a == A_CMD);
      m_taint = 0;
    end else if (r && m_win) begin
      if (mr) begin set = 1; m_win = 0; end
      else m_taint = 1;
    end
    if (clr) m_err = 0;
    else if (set) m_err = 1;
  endtask

  task automatic op(input string tag, input logic w, input logic r, input logic mr,
                    input logic [7:0] a, input logic [7:0] d,
                    input logic b = 0, input logic [2:0] p = 0);
    @(negedge clk);
    wr = w; rd = r; rmw = mr; addr = a; wdata = d; bt = b; pos = p;
    #1;
    if (r) chk({tag, " read"}, rdata, exp_rd(a));
    model_step(w, r, mr, a, d, b, p);
    @(posedge clk); #1;
    wr = 0; rd = 0; rmw = 0;
    chk({tag, " flag"}, {7'b0, perr}, {7'b0, m_err});
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    op(tag, 0, 1, 0, a, 0);
    chk(tag, exp_rd(a), exp);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) m_spec[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 flag", {7'b0, perr}, 8'h00);
    rdchk("R1 stat", A_STAT, 8'h00);
    rdchk("R1 spec0", A_SP0, 8'h00);
    rdchk("R1 spec2", A_SP2, 8'h00);
    // R3 unlock then write
    op("R3", 1, 0, 0, A_CMD, 8'hA5); op("R3", 1, 0, 0, A_SP1, 8'h3C);
    rdchk("R3 byte", A_SP1, 8'h3C);
    op("R3", 1, 0, 0, A_CMD, 0); op("R3", 1, 0, 0, A_SP1, 8'h01, 1, 3'd7);
    rdchk("R3 bit", A_SP1, 8'hBC);
    chk("R3 noerr", {7'b0, perr}, 8'h00);
    // R4 unguarded write
    op("R4", 1, 0, 0, A_SP2, 8'hFF);
    rdchk("R4 discard", A_SP2, 8'h00);
    chk("R4 err", {7'b0, perr}, 8'h01);
    // R9 set-1 no effect, other bit no effect, clear by bit 0
    op("R9", 1, 0, 0, A_STAT, 8'h01);
    chk("R9 w1", {7'b0, perr}, 8'h01);
    op("R9", 1, 0, 0, A_STAT, 8'h00, 1, 3'd3);
    chk("R9 bit3", {7'b0, perr}, 8'h01);
    op("R9", 1, 0, 0, A_STAT, 8'h00, 1, 3'd0);
    chk("R9 clr", {7'b0, perr}, 8'h00);
    // R5 foreign write inside window
    op("R5", 1, 0, 0, A_CMD, 0); op("R5", 1, 0, 1, A_OTH, 8'h11);
    chk("R5 err", {7'b0, perr}, 8'h01);
    op("R5", 1, 0, 0, A_SP1, 8'h22);
    rdchk("R5 closed", A_SP1, 8'hBC);
    // R2 status reads hide upper bits
    rdchk("R2", A_STAT, 8'h01);
    // R10 clear after cmd wins
    op("R10", 1, 0, 0, A_CMD, 0); op("R10", 1, 0, 0, A_STAT, 8'hFE);
    chk("R10", {7'b0, perr}, 8'h00);
    // R6 plain read keeps window for spec2
    op("R6", 1, 0, 0, A_CMD, 0); op("R6", 0, 1, 0, A_OTH, 0);
    op("R6", 1, 0, 0, A_SP2, 8'h77);
    rdchk("R6", A_SP2, 8'h77);
    chk("R6 noerr", {7'b0, perr}, 8'h00);
    // R7 strict slot after read
    op("R7", 1, 0, 0, A_CMD, 0); op("R7", 0, 1, 0, A_SP1, 0);
    op("R7", 1, 0, 0, A_SP0, 8'h55);
    rdchk("R7 discard", A_SP0, 8'h00);
    chk("R7 err", {7'b0, perr}, 8'h01);
    op("R7", 1, 0, 0, A_STAT, 0);
    op("R7", 1, 0, 0, A_CMD, 0); op("R7", 1, 0, 0, A_SP0, 8'h55);
    rdchk("R7 ok", A_SP0, 8'h55);
    // R8 rmw read breaks window
    op("R8", 1, 0, 0, A_CMD, 0); op("R8", 0, 1, 1, A_SP1, 0);
    chk("R8 err", {7'b0, perr}, 8'h01);
    op("R8", 1, 0, 0, A_SP1, 8'h00);
    rdchk("R8 closed", A_SP1, 8'hBC);
    op("R8", 1, 0, 0, A_STAT, 0);
    // R11 cmd reads zero
    op("R11", 1, 0, 0, A_CMD, 8'hFF);
    rdchk("R11", A_CMD, 8'h00);
    op("R11", 1, 0, 0, A_STAT, 0);
    // R12 double cmd
    op("R12", 1, 0, 0, A_CMD, 0); op("R12", 1, 0, 0, A_CMD, 0);
    chk("R12 err", {7'b0, perr}, 8'h01);
    op("R12", 1, 0, 0, A_SP2, 8'h99);
    rdchk("R12 reopen", A_SP2, 8'h99);
    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] a, d;
      logic b, mr;
      logic [2:0] p;
      d = 8'($urandom); b = 1'($urandom_range(0, 3) == 0); p = 3'($urandom);
      mr = 1'($urandom);
      case ($urandom_range(0, 5))
        0: a = A_CMD; 1: a = A_STAT; 2: a = A_SP0; 3: a = A_SP1; 4: a = A_SP2;
        default: a = A_OTH;
      endcase
      if (sel < 3) op("R5 rnd", 1, 0, 0, A_CMD, d);
      else if (sel < 7) op("R3 rnd", 1, 0, mr, a, d, b, p);
      else if (sel < 9) op("R6 rnd", 0, 1, 0, a, 0);
      else op("R8 rnd", 0, 1, 1, a, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule